// File: doc/BRIEF.md
# Double Row Buffer

This block is a two-bank line store for a character display pipeline. One bank collects the character codes of the next display row from a write port. At the same time the other bank is played back, one byte per read strobe, for the row now on screen. The two ports have separate strobe inputs. Both strobes are sampled as synchronous enables of a single system clock, so the block acts on the rising edge of each strobe.

A falling edge on the clear input arms a pending request. The next rising read strobe carries out the request. It always rewinds the read pointer. When the toggle input is low, it also swaps the roles of the two banks and rewinds the write pointer. The read enable, the AND of the two write enables and the write data are all captured on a strobe edge, so each of them acts on the following strobe of its port. Each port has an overflow flag that rises when its counter reaches one less than the depth.

Top module: `dbl_row_buf`

## Requirements
- R1: After reset, rd_data_o is 0, rd_ovf_o and wr_ovf_o are 0, both counters are 0, no clear is pending, and bank 0 is the write bank.
- R2: Writes go into the write bank. Reads come from the other bank. A byte written before a swap is read back, in write order, after that swap.
- R3: A falling edge of clr_i sets a pending flag. The next rising edge of rd_clk_i services the flag and clears it. Servicing sets the read counter to 0 and clears rd_ovf_o. A read on that same edge fetches entry 0.
- R4: If tog_i is low when the pending flag is serviced, the banks swap, the write counter goes to 0 and wr_ovf_o clears. If tog_i is high, only the read side is rewound and the bank roles are kept.
- R5: rd_en_i is sampled on every rising rd_clk_i edge. A byte is output and the read counter advances only when the previous sample was 1 and the counter is below DEPTH. Otherwise rd_data_o holds its value.
- R6: rd_ovf_o goes to 1 when the read counter equals DEPTH-1 after an increment. No read happens once the counter reaches DEPTH.
- R7: On a rising wr_clk_i edge with wr_en_a_i and wr_en_b_i both 1, wr_data_i is latched. The AND of the two enables is registered. With only one enable high, nothing is latched and the next edge writes nothing.
- R8: The latched byte is written at the write counter on the next rising wr_clk_i edge if the registered enable is 1 and the counter is below DEPTH. wr_ovf_o goes to 1 when the counter equals DEPTH-1 after an increment. Writes beyond DEPTH entries are discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_clk_i | input | 1 | Write strobe, acts on its rising edge |
| wr_en_a_i | input | 1 | First write enable |
| wr_en_b_i | input | 1 | Second write enable |
| wr_data_i | input | WIDTH | Write byte |
| rd_clk_i | input | 1 | Read strobe, acts on its rising edge |
| rd_en_i | input | 1 | Read enable |
| clr_i | input | 1 | Clear request, armed on its falling edge |
| tog_i | input | 1 | Low: swap banks on clear; high: rewind read side only |
| rd_data_o | output | WIDTH | Last byte read |
| rd_ovf_o | output | 1 | Read overflow flag |
| wr_ovf_o | output | 1 | Write overflow flag |

## Verification
A strobe level change is seen on the first system clock edge where the new level is present. The data output, both flags and the counters change on that same edge, so results are due one system clock after the strobe rises. Enables and write data act one strobe later. A write therefore appears only on the strobe that follows its capture, and a read enable affects the read strobe after the one that sampled it. Each strobe in the bench is raised at a falling clock edge and dropped at the next one, and the outputs are compared at that second falling edge, after the design has acted. A bench model tracks bank, counters and registered enables per strobe to give the expected byte for every strobe.

// File: rtl/drb_pkg.sv
package drb_pkg;
  typedef struct packed {
    logic rise;
    logic fall;
  } edge_t;

  localparam int unsigned N_EDGE = 3;
  localparam int unsigned E_RCLK = 0;
  localparam int unsigned E_WCLK = 1;
  localparam int unsigned E_CLR  = 2;
endpackage

// File: rtl/drb_edge.sv
module drb_edge (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           sig_i,
  output drb_pkg::edge_t edge_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sig_i;
  end

  assign edge_o.rise = sig_i & ~prev_q;
  assign edge_o.fall = ~sig_i & prev_q;
endmodule

// File: rtl/drb_ctrl.sv
module drb_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rclk_rise_i,
  input  logic clr_fall_i,
  input  logic tog_i,
  output logic svc_o,
  output logic swap_o,
  output logic bank_o,
  output logic bank_nxt_o
);
  logic pend_q, bank_q;

  assign svc_o      = pend_q & rclk_rise_i;
  assign swap_o     = svc_o & ~tog_i;
  assign bank_o     = bank_q;
  assign bank_nxt_o = bank_q ^ swap_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      bank_q <= 1'b0;
    end else begin
      pend_q <= clr_fall_i | (pend_q & ~rclk_rise_i);
      bank_q <= bank_nxt_o;
    end
  end
endmodule

// File: rtl/drb_store.sv
module drb_store #(
  parameter int unsigned DEPTH = 135,
  parameter int unsigned WIDTH = 8,
  parameter int unsigned AW    = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             we_i,
  input  logic             wbank_i,
  input  logic [AW-1:0]    waddr_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic             rbank_i,
  input  logic [AW-1:0]    raddr_i,
  output logic [WIDTH-1:0] rdata_o
);
  logic [WIDTH-1:0] mem_q [2][DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[wbank_i][waddr_i] <= wdata_i;
  end

  assign rdata_o = (raddr_i < AW'(DEPTH)) ? mem_q[rbank_i][raddr_i] : '0;
endmodule

// File: rtl/drb_read.sv
module drb_read #(
  parameter int unsigned DEPTH = 135,
  parameter int unsigned WIDTH = 8,
  parameter int unsigned AW    = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rise_i,
  input  logic             svc_i,
  input  logic             en_i,
  input  logic [WIDTH-1:0] mem_data_i,
  output logic [AW-1:0]    addr_o,
  output logic [AW-1:0]    cnt_o,
  output logic [WIDTH-1:0] data_o,
  output logic             ovf_o
);
  localparam logic [AW-1:0] LIMIT = AW'(DEPTH);
  localparam logic [AW-1:0] FLAG  = AW'(DEPTH - 1);

  logic [AW-1:0]    cnt_q;
  logic [WIDTH-1:0] data_q;
  logic             en_q, ovf_q, fire;

  assign addr_o = svc_i ? '0 : cnt_q;
  assign fire   = rise_i & en_q & (addr_o < LIMIT);
  assign cnt_o  = cnt_q;
  assign data_o = data_q;
  assign ovf_o  = ovf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      data_q <= '0;
      en_q   <= 1'b0;
      ovf_q  <= 1'b0;
    end else if (rise_i) begin
      if (svc_i) begin
        cnt_q <= '0;
        ovf_q <= 1'b0;
      end
      if (fire) begin
        data_q <= mem_data_i;
        cnt_q  <= addr_o + AW'(1);
        if (addr_o + AW'(1) == FLAG) ovf_q <= 1'b1;
      end
      en_q <= en_i;
    end
  end
endmodule

// File: rtl/drb_write.sv
module drb_write #(
  parameter int unsigned DEPTH = 135,
  parameter int unsigned WIDTH = 8,
  parameter int unsigned AW    = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rise_i,
  input  logic             swap_i,
  input  logic             en_a_i,
  input  logic             en_b_i,
  input  logic [WIDTH-1:0] data_i,
  output logic             we_o,
  output logic [AW-1:0]    addr_o,
  output logic [WIDTH-1:0] wdata_o,
  output logic             ovf_o
);
  localparam logic [AW-1:0] LIMIT = AW'(DEPTH);
  localparam logic [AW-1:0] FLAG  = AW'(DEPTH - 1);

  logic [AW-1:0]    cnt_q;
  logic [WIDTH-1:0] latch_q;
  logic             en_q, ovf_q, both;

  assign both    = en_a_i & en_b_i;
  // a swap on the same system clock wins over the write
  assign we_o    = rise_i & en_q & (cnt_q < LIMIT) & ~swap_i;
  assign addr_o  = cnt_q;
  assign wdata_o = latch_q;
  assign ovf_o   = ovf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      latch_q <= '0;
      en_q    <= 1'b0;
      ovf_q   <= 1'b0;
    end else begin
      if (swap_i) begin
        cnt_q <= '0;
        ovf_q <= 1'b0;
      end else if (we_o) begin
        cnt_q <= cnt_q + AW'(1);
        if (cnt_q + AW'(1) == FLAG) ovf_q <= 1'b1;
      end
      if (rise_i) begin
        if (both) latch_q <= data_i;
        en_q <= both;
      end
    end
  end
endmodule

// File: rtl/dbl_row_buf.sv
module dbl_row_buf #(
  parameter int unsigned DEPTH = 135,
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_clk_i,
  input  logic             wr_en_a_i,
  input  logic             wr_en_b_i,
  input  logic [WIDTH-1:0] wr_data_i,
  input  logic             rd_clk_i,
  input  logic             rd_en_i,
  input  logic             clr_i,
  input  logic             tog_i,
  output logic [WIDTH-1:0] rd_data_o,
  output logic             rd_ovf_o,
  output logic             wr_ovf_o
);
  import drb_pkg::*;
  localparam int unsigned AW = $clog2(DEPTH + 1);

  logic [N_EDGE-1:0] strobes;
  edge_t             edges [N_EDGE];

  assign strobes[E_RCLK] = rd_clk_i;
  assign strobes[E_WCLK] = wr_clk_i;
  assign strobes[E_CLR]  = clr_i;

  for (genvar g = 0; g < N_EDGE; g++) begin : g_edge
    drb_edge edge_i (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .sig_i (strobes[g]),
      .edge_o(edges[g])
    );
  end

  logic rclk_rise, wclk_rise, clr_fall;
  assign rclk_rise = edges[E_RCLK].rise;
  assign wclk_rise = edges[E_WCLK].rise;
  assign clr_fall  = edges[E_CLR].fall;

  logic svc, swap, bank_q, bank_nxt;

  drb_ctrl ctrl_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rclk_rise_i(rclk_rise),
    .clr_fall_i (clr_fall),
    .tog_i      (tog_i),
    .svc_o      (svc),
    .swap_o     (swap),
    .bank_o     (bank_q),
    .bank_nxt_o (bank_nxt)
  );

  logic             we;
  logic [AW-1:0]    waddr, raddr, rac;
  logic [WIDTH-1:0] wdata, rdata;

  drb_write #(.DEPTH(DEPTH), .WIDTH(WIDTH), .AW(AW)) wr_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rise_i (wclk_rise),
    .swap_i (swap),
    .en_a_i (wr_en_a_i),
    .en_b_i (wr_en_b_i),
    .data_i (wr_data_i),
    .we_o   (we),
    .addr_o (waddr),
    .wdata_o(wdata),
    .ovf_o  (wr_ovf_o)
  );

  drb_store #(.DEPTH(DEPTH), .WIDTH(WIDTH), .AW(AW)) mem_i (
    .clk_i  (clk_i),
    .we_i   (we),
    .wbank_i(bank_q),
    .waddr_i(waddr),
    .wdata_i(wdata),
    .rbank_i(~bank_nxt),
    .raddr_i(raddr),
    .rdata_o(rdata)
  );

  drb_read #(.DEPTH(DEPTH), .WIDTH(WIDTH), .AW(AW)) rd_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rise_i    (rclk_rise),
    .svc_i     (svc),
    .en_i      (rd_en_i),
    .mem_data_i(rdata),
    .addr_o    (raddr),
    .cnt_o     (rac),
    .data_o    (rd_data_o),
    .ovf_o     (rd_ovf_o)
  );
endmodule

// File: rtl/drb_checker.sv
module drb_checker #(
  parameter int unsigned DEPTH = 135,
  parameter int unsigned WIDTH = 8,
  parameter int unsigned AW    = $clog2(DEPTH + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             rclk_rise,
  input logic             wclk_rise,
  input logic             svc,
  input logic             tog_i,
  input logic             bank_q,
  input logic [AW-1:0]    rac,
  input logic [AW-1:0]    waddr,
  input logic [WIDTH-1:0] rd_data_o,
  input logic             rd_ovf_o,
  input logic             wr_ovf_o
);
  assert_svc_rewind_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    svc |=> (rac <= AW'(1)));

  assert_swap_bank_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (svc && !tog_i) |=> (bank_q != $past(bank_q)) && (waddr == '0) && !wr_ovf_o);

  assert_keep_bank_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (svc && tog_i) |=> $stable(bank_q));

  assert_read_idle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rclk_rise |=> $stable(rd_data_o) && $stable(rd_ovf_o) && $stable(rac));

  assert_read_bound_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rac <= AW'(DEPTH));

  assert_write_bound_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    waddr <= AW'(DEPTH));

  assert_write_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wclk_rise && !svc) |=> $stable(waddr) && $stable(wr_ovf_o));
endmodule

bind dbl_row_buf drb_checker #(.DEPTH(DEPTH), .WIDTH(WIDTH), .AW(AW)) chk_i (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .rclk_rise(rclk_rise),
  .wclk_rise(wclk_rise),
  .svc      (svc),
  .tog_i    (tog_i),
  .bank_q   (bank_q),
  .rac      (rac),
  .waddr    (waddr),
  .rd_data_o(rd_data_o),
  .rd_ovf_o (rd_ovf_o),
  .wr_ovf_o (wr_ovf_o)
);

// File: tb/dbl_row_buf_tb_top.sv
`timescale 1ns/1ps
module dbl_row_buf_tb_top;
  localparam int D = 135;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wclk = 0, wen_a = 0, wen_b = 0, rclk = 0, ren = 0, clr = 0, tog = 0;
  logic [7:0] wdat = 0;
  logic [7:0] rdat;
  logic       rof, wof;

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  dbl_row_buf dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .wr_clk_i(wclk), .wr_en_a_i(wen_a), .wr_en_b_i(wen_b), .wr_data_i(wdat),
    .rd_clk_i(rclk), .rd_en_i(ren), .clr_i(clr), .tog_i(tog),
    .rd_data_o(rdat), .rd_ovf_o(rof), .wr_ovf_o(wof)
  );

  // behavioural model of the requirements
  logic [7:0] m_mem [2][D];
  int         m_wac = 0, m_rac = 0;
  logic       m_bank = 0, m_pend = 0, m_renq = 0, m_wenq = 0, m_rof = 0, m_wof = 0;
  logic [7:0] m_latch = 0, m_dout = 0;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wpulse(input logic a, input logic b, input logic [7:0] d);
    @(negedge clk); wen_a = a; wen_b = b; wdat = d; wclk = 1'b1;
    @(negedge clk); wclk = 1'b0;
    if (m_wenq && m_wac < D) begin
      m_mem[m_bank][m_wac] = m_latch;
      m_wac++;
      if (m_wac == D - 1) m_wof = 1'b1;
    end
    if (a && b) m_latch = d;
    m_wenq = a && b;
    check("R8 wr_ovf", {7'd0, wof}, {7'd0, m_wof});
  endtask

  task automatic rpulse(input logic r, input logic t);
    @(negedge clk); ren = r; tog = t; rclk = 1'b1;
    @(negedge clk); rclk = 1'b0;
    if (m_pend) begin
      m_rac = 0; m_rof = 0;
      if (!t) begin m_bank = ~m_bank; m_wac = 0; m_wof = 0; end
      m_pend = 0;
    end
    if (m_renq && m_rac < D) begin
      m_dout = m_mem[~m_bank][m_rac];
      m_rac++;
      if (m_rac == D - 1) m_rof = 1'b1;
    end
    m_renq = r;
    check("R5 rd_data", rdat, m_dout);
    check("R6 rd_ovf", {7'd0, rof}, {7'd0, m_rof});
    check("R4 wr_ovf", {7'd0, wof}, {7'd0, m_wof});
  endtask

  task automatic arm();
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    @(negedge clk);
    m_pend = 1'b1;
  endtask

  task automatic write_row(input int n, input logic [7:0] seed);
    for (int k = 0; k < n; k++) wpulse(1'b1, 1'b1, seed ^ 8'(k));
    wpulse(1'b0, 1'b0, 8'hee);
  endtask

  task automatic t_reset();
    check("R1 rd_data", rdat, 8'h00);
    check("R1 rd_ovf", {7'd0, rof}, 8'h00);
    check("R1 wr_ovf", {7'd0, wof}, 8'h00);
  endtask

  task automatic t_fill_swap();
    write_row(5, 8'h40);
    arm();
    rpulse(1'b1, 1'b0);
    check("R3 no read on service edge", rdat, 8'h00);
    for (int k = 0; k < 4; k++) begin
      rpulse(1'b1, 1'b0);
      check("R2 row read", rdat, 8'h40 ^ 8'(k));
    end
    rpulse(1'b0, 1'b0);
    check("R5 delayed enable", rdat, 8'h44);
    rpulse(1'b0, 1'b0);
    check("R5 hold", rdat, 8'h44);
  endtask

  task automatic t_rewind();
    write_row(4, 8'h80);
    arm();
    rpulse(1'b1, 1'b1);
    rpulse(1'b1, 1'b1);
    check("R4 rewind keeps bank", rdat, 8'h40);
    rpulse(1'b1, 1'b1);
    check("R4 rewind second", rdat, 8'h41);
    arm();
    rpulse(1'b1, 1'b0);
    check("R3 same-edge read entry 0", rdat, 8'h80);
    rpulse(1'b1, 1'b0);
    check("R2 second row", rdat, 8'h81);
  endtask

  task automatic t_enable();
    wpulse(1'b1, 1'b1, 8'h11);
    wpulse(1'b1, 1'b0, 8'h22);
    wpulse(1'b0, 1'b1, 8'h2a);
    wpulse(1'b1, 1'b1, 8'h33);
    wpulse(1'b0, 1'b0, 8'h00);
    arm();
    rpulse(1'b1, 1'b0);
    check("R7 first kept", rdat, 8'h11);
    rpulse(1'b1, 1'b0);
    check("R7 single enable ignored", rdat, 8'h33);
  endtask

  task automatic t_overflow();
    arm();
    rpulse(1'b0, 1'b0);
    check("R4 wac cleared wof", {7'd0, wof}, 8'h00);
    for (int k = 0; k < D + 2; k++) wpulse(1'b1, 1'b1, 8'h5a ^ 8'(k));
    wpulse(1'b0, 1'b0, 8'h00);
    check("R8 wof set", {7'd0, wof}, 8'h01);
    arm();
    rpulse(1'b1, 1'b0);
    check("R4 swap clears wof", {7'd0, wof}, 8'h00);
    for (int k = 0; k < D + 2; k++) rpulse(1'b1, 1'b0);
    check("R8 last kept entry", rdat, 8'h5a ^ 8'(D - 1));
    check("R6 rof set", {7'd0, rof}, 8'h01);
    arm();
    rpulse(1'b0, 1'b1);
    check("R3 rof cleared", {7'd0, rof}, 8'h00);
  endtask

  initial begin
    #100000000;
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_fill_swap();
    t_rewind();
    t_enable();
    t_overflow();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule